// File: doc/BRIEF.md
# Strided Memory-to-Stream Read Mover

This block sits between a strided address generator and a memory read port. It takes element addresses one at a time, turns them into read requests, collects the read data and sends the elements out on an AXI4-Stream interface in the order the addresses arrived. Each address carries three flags. One says the descriptor it belongs to walks its innermost dimension with unit stride. One marks the last element of an innermost row. One marks the last element of the whole descriptor.

With unit innermost stride, consecutive addresses are merged into one burst request. The burst closes at the end of the row, at the end of the descriptor, or when it reaches the configured maximum length. With any other stride, every element becomes its own single-beat request. A credit counter limits the number of element beats that have been requested but not yet sent on the stream, so the response buffer can never overflow, and a stalled stream stalls the memory responses without losing data. TLAST goes high on the final element of each descriptor.

Top module: `strided_rd_mover`

## Requirements
- R1: With `ag_unit` high, consecutive accepted addresses form one request whose `mrq_addr` is the first address and whose `mrq_len` (a beat count, 1 means a single element) equals the number of merged addresses. The burst closes on an address flagged `ag_row_end` or `ag_desc_end`.
- R2: No request is longer than MAX_BURST beats. A unit-stride row longer than MAX_BURST is split into requests of MAX_BURST beats and a shorter remainder.
- R3: An address accepted with `ag_unit` low produces exactly one request of length 1 at that address.
- R4: Stream elements leave in address-arrival order, each carrying the memory word of its address, and `st_tdata`/`st_tlast` stay stable while `st_tvalid` is high and `st_tready` is low.
- R5: `st_tlast` is high on the element whose address carried `ag_desc_end` and low on all other elements.
- R6: Beats requested but not yet sent on the stream never exceed MAX_OUTST. A request that would exceed this is held back.
- R7: While the stream is stalled, responses are refused (`mrs_ready` low) once the buffer holds MAX_OUTST beats, and no beat is lost.
- R8: While reset is asserted, `mrq_valid` and `st_tvalid` are low and `ag_ready` is high.
- R9: Once `mrq_valid` is high, it stays high with `mrq_addr` and `mrq_len` unchanged until `mrq_ready` accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ag_valid | input | 1 | Element address valid |
| ag_ready | output | 1 | Element address accepted |
| ag_addr | input | AW | Element address |
| ag_unit | input | 1 | Innermost stride of this descriptor is 1 |
| ag_row_end | input | 1 | Last element of an innermost row |
| ag_desc_end | input | 1 | Last element of the descriptor |
| mrq_valid | output | 1 | Read request valid |
| mrq_ready | input | 1 | Read request accepted |
| mrq_addr | output | AW | First element address of the request |
| mrq_len | output | $clog2(MAX_BURST+1) | Beat count of the request |
| mrs_valid | input | 1 | Read data valid |
| mrs_ready | output | 1 | Read data accepted |
| mrs_data | input | EW | Read data, one element per beat, in request order |
| st_tvalid | output | 1 | Stream data valid |
| st_tready | input | 1 | Stream consumer ready |
| st_tdata | output | EW | Stream element |
| st_tlast | output | 1 | Final element of a descriptor |

## Verification
An address that closes a burst is taken at a clock edge and its request is visible on `mrq_addr`/`mrq_len` during the following cycle, or later if credit or the request handshake holds it back. A response beat accepted at an edge reaches `st_tdata` in the next cycle when the buffer was empty. Because credit, random ready signals and random memory latency move these points, the bench does not assume fixed delays: it samples every handshake shortly before each rising edge and compares each completed request and each stream element with the head of its expected queue. The stall phase is checked at one fixed cycle, long after the buffer must have filled.

// File: rtl/rdm_pkg.sv
package rdm_pkg;

  typedef enum logic [0:0] {
    BF_COLLECT = 1'b0,
    BF_PEND    = 1'b1
  } bf_state_e;

endpackage

// File: rtl/rdm_fifo.sv
module rdm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [IW-1:0] wr_idx_q, wr_idx_d, rd_idx_q, rd_idx_d;
  logic [NW-1:0] fill_q, fill_d;
  logic          do_wr, do_rd;

  assign full    = (fill_q == NW'(DEPTH));
  assign empty   = (fill_q == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem_q[rd_idx_q];

  always_comb begin
    wr_idx_d = wr_idx_q;
    rd_idx_d = rd_idx_q;
    fill_d   = fill_q;
    if (do_wr) begin
      wr_idx_d = (wr_idx_q == IW'(DEPTH - 1)) ? '0 : wr_idx_q + IW'(1);
    end
    if (do_rd) begin
      rd_idx_d = (rd_idx_q == IW'(DEPTH - 1)) ? '0 : rd_idx_q + IW'(1);
    end
    if (do_wr && !do_rd) begin
      fill_d = fill_q + NW'(1);
    end else if (do_rd && !do_wr) begin
      fill_d = fill_q - NW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      fill_q   <= '0;
    end else begin
      wr_idx_q <= wr_idx_d;
      rd_idx_q <= rd_idx_d;
      fill_q   <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      mem_q[wr_idx_q] <= wr_data;
    end
  end

endmodule

// File: rtl/rdm_burst_former.sv
module rdm_burst_former
  import rdm_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MAX_BURST = 32,
  parameter int LENW      = $clog2(MAX_BURST + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [AW-1:0]   in_addr,
  input  logic            in_unit,
  input  logic            in_row_end,
  input  logic            in_desc_end,
  output logic            out_valid,
  input  logic            out_take,
  output logic [AW-1:0]   out_addr,
  output logic [LENW-1:0] out_len,
  output logic            out_last
);
  bf_state_e       st_q, st_d;
  logic [AW-1:0]   base_q, base_d;
  logic [LENW-1:0] cnt_q, cnt_d, cnt_inc;
  logic            last_q, last_d;
  logic            accept, close_now;

  assign in_ready  = (st_q == BF_COLLECT);
  assign accept    = in_valid && in_ready;
  assign cnt_inc   = cnt_q + LENW'(1);
  assign close_now = !in_unit || in_row_end || in_desc_end ||
                     (cnt_inc == LENW'(MAX_BURST));

  assign out_valid = (st_q == BF_PEND);
  assign out_addr  = base_q;
  assign out_len   = cnt_q;
  assign out_last  = last_q;

  always_comb begin
    st_d   = st_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    if (accept) begin
      if (cnt_q == '0) begin
        base_d = in_addr;
      end
      cnt_d  = cnt_inc;
      last_d = in_desc_end;
      if (close_now) begin
        st_d = BF_PEND;
      end
    end
    if ((st_q == BF_PEND) && out_take) begin
      st_d  = BF_COLLECT;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BF_COLLECT;
      base_q <= '0;
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/strided_rd_mover.sv
module strided_rd_mover #(
  parameter int EW        = 64,
  parameter int AW        = 32,
  parameter int MAX_BURST = 32,
  parameter int MAX_OUTST = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ag_valid,
  output logic                             ag_ready,
  input  logic [AW-1:0]                    ag_addr,
  input  logic                             ag_unit,
  input  logic                             ag_row_end,
  input  logic                             ag_desc_end,
  output logic                             mrq_valid,
  input  logic                             mrq_ready,
  output logic [AW-1:0]                    mrq_addr,
  output logic [$clog2(MAX_BURST+1)-1:0]   mrq_len,
  input  logic                             mrs_valid,
  output logic                             mrs_ready,
  input  logic [EW-1:0]                    mrs_data,
  output logic                             st_tvalid,
  input  logic                             st_tready,
  output logic [EW-1:0]                    st_tdata,
  output logic                             st_tlast
);
  localparam int LENW = $clog2(MAX_BURST + 1);
  localparam int CW   = $clog2(MAX_OUTST + 1);
  localparam int CW1  = CW + 1;
  localparam int TAGW = LENW + 1;
  localparam int DW   = EW + 1;

  if (!(EW == 32 || EW == 64 || EW == 128 || EW == 256 || EW == 512)) begin : g_bad_ew
    $error("element width must be 32, 64, 128, 256 or 512");
  end
  if (MAX_BURST > MAX_OUTST || MAX_BURST < 1) begin : g_bad_burst
    $error("MAX_BURST must lie between 1 and MAX_OUTST");
  end

  // burst forming
  logic            bf_valid, bf_take, bf_last;
  logic [AW-1:0]   bf_addr;
  logic [LENW-1:0] bf_len;

  rdm_burst_former #(
    .AW(AW), .MAX_BURST(MAX_BURST), .LENW(LENW)
  ) u_former (
    .clk(clk), .rst_n(rst_n),
    .in_valid(ag_valid), .in_ready(ag_ready), .in_addr(ag_addr),
    .in_unit(ag_unit), .in_row_end(ag_row_end), .in_desc_end(ag_desc_end),
    .out_valid(bf_valid), .out_take(bf_take),
    .out_addr(bf_addr), .out_len(bf_len), .out_last(bf_last)
  );

  // credit: beats requested and not yet sent on the stream
  logic [CW-1:0]  credit_q, credit_d;
  logic [CW1-1:0] credit_need;
  logic           tag_full, tag_empty;
  logic           req_fire, rsp_fire, out_fire;

  assign credit_need = CW1'(credit_q) + CW1'(bf_len);
  assign mrq_valid   = bf_valid && !tag_full && (credit_need <= CW1'(MAX_OUTST));
  assign mrq_addr    = bf_addr;
  assign mrq_len     = bf_len;
  assign req_fire    = mrq_valid && mrq_ready;
  assign bf_take     = req_fire;
  assign out_fire    = st_tvalid && st_tready;

  always_comb begin
    credit_d = credit_q;
    if (req_fire) begin
      credit_d = credit_d + CW'(bf_len);
    end
    if (out_fire) begin
      credit_d = credit_d - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit_q <= '0;
    end else begin
      credit_q <= credit_d;
    end
  end

  // per-request tags: length and descriptor-end flag
  logic [TAGW-1:0] tag_rd;
  logic [LENW-1:0] tag_len;
  logic            tag_last, tag_pop;

  rdm_fifo #(.W(TAGW), .DEPTH(MAX_OUTST)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .wr_en(req_fire), .wr_data({bf_last, bf_len}),
    .rd_en(tag_pop), .rd_data(tag_rd),
    .full(tag_full), .empty(tag_empty)
  );

  assign tag_len  = tag_rd[LENW-1:0];
  assign tag_last = tag_rd[TAGW-1];

  // response beats
  logic [LENW-1:0] beat_q, beat_d;
  logic            final_beat;
  logic            df_full, df_empty;
  logic [DW-1:0]   df_rd;

  assign mrs_ready  = !df_full && !tag_empty;
  assign rsp_fire   = mrs_valid && mrs_ready;
  assign final_beat = ((beat_q + LENW'(1)) == tag_len);
  assign tag_pop    = rsp_fire && final_beat;

  always_comb begin
    beat_d = beat_q;
    if (rsp_fire) begin
      beat_d = final_beat ? '0 : beat_q + LENW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else begin
      beat_q <= beat_d;
    end
  end

  rdm_fifo #(.W(DW), .DEPTH(MAX_OUTST)) u_data (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rsp_fire), .wr_data({final_beat && tag_last, mrs_data}),
    .rd_en(out_fire), .rd_data(df_rd),
    .full(df_full), .empty(df_empty)
  );

  assign st_tvalid = !df_empty;
  assign st_tdata  = df_rd[EW-1:0];
  assign st_tlast  = df_rd[DW-1];

endmodule

// File: rtl/rdm_checker.sv
module rdm_checker #(
  parameter int EW        = 64,
  parameter int AW        = 32,
  parameter int MAX_BURST = 32,
  parameter int MAX_OUTST = 32,
  parameter int LENW      = $clog2(MAX_BURST + 1),
  parameter int CW        = $clog2(MAX_OUTST + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mrq_valid,
  input logic            mrq_ready,
  input logic [AW-1:0]   mrq_addr,
  input logic [LENW-1:0] mrq_len,
  input logic            mrs_ready,
  input logic            st_tvalid,
  input logic            st_tready,
  input logic [EW-1:0]   st_tdata,
  input logic            st_tlast,
  input logic [CW-1:0]   credit,
  input logic            df_full
);

  p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mrq_valid |-> (mrq_len != '0) && (mrq_len <= LENW'(MAX_BURST)));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mrq_valid && !mrq_ready) |=> (mrq_valid && $stable(mrq_addr) && $stable(mrq_len)));

  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_tvalid && !st_tready) |=> (st_tvalid && $stable(st_tdata) && $stable(st_tlast)));

  p_credit_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    credit <= CW'(MAX_OUTST));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    df_full |-> !mrs_ready);

endmodule

bind strided_rd_mover rdm_checker #(
  .EW(EW), .AW(AW), .MAX_BURST(MAX_BURST), .MAX_OUTST(MAX_OUTST)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mrq_valid(mrq_valid), .mrq_ready(mrq_ready),
  .mrq_addr(mrq_addr), .mrq_len(mrq_len),
  .mrs_ready(mrs_ready),
  .st_tvalid(st_tvalid), .st_tready(st_tready),
  .st_tdata(st_tdata), .st_tlast(st_tlast),
  .credit(credit_q), .df_full(df_full)
);

// File: tb/sim_strided_rd_mover.sv
module sim_strided_rd_mover;
  localparam int EW = 64;
  localparam int AW = 16;
  localparam int MB = 4;
  localparam int MO = 8;
  localparam int LENW = $clog2(MB + 1);

  logic clk, rst_n;
  logic ag_valid, ag_ready, ag_unit, ag_row_end, ag_desc_end;
  logic [AW-1:0] ag_addr;
  logic mrq_valid, mrq_ready;
  logic [AW-1:0] mrq_addr;
  logic [LENW-1:0] mrq_len;
  logic mrs_valid, mrs_ready;
  logic [EW-1:0] mrs_data;
  logic st_tvalid, st_tready, st_tlast;
  logic [EW-1:0] st_tdata;

  strided_rd_mover #(.EW(EW), .AW(AW), .MAX_BURST(MB), .MAX_OUTST(MO)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ag_valid(ag_valid), .ag_ready(ag_ready), .ag_addr(ag_addr),
    .ag_unit(ag_unit), .ag_row_end(ag_row_end), .ag_desc_end(ag_desc_end),
    .mrq_valid(mrq_valid), .mrq_ready(mrq_ready), .mrq_addr(mrq_addr), .mrq_len(mrq_len),
    .mrs_valid(mrs_valid), .mrs_ready(mrs_ready), .mrs_data(mrs_data),
    .st_tvalid(st_tvalid), .st_tready(st_tready), .st_tdata(st_tdata), .st_tlast(st_tlast)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct { int addr; bit unit; bit row; bit desc; } elem_t;
  typedef struct { int addr; int len; } req_t;
  typedef struct { logic [EW-1:0] data; bit last; } out_t;

  elem_t addr_q[$];
  req_t  exp_req_q[$];
  out_t  exp_out_q[$];
  int    rsp_q[$];

  int total = 0;
  int bad = 0;
  int inflight = 0;
  int occ = 0;
  int open_base = 0;
  int open_cnt = 0;

  function automatic logic [EW-1:0] memval(input int a);
    logic [15:0] w;
    w = 16'(a);
    return {w, ~w, w ^ 16'h3c3c, w + 16'h1111};
  endfunction

  task automatic check(input bit ok, input string req, input logic [EW-1:0] act,
                       input logic [EW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected behaviour from the requirements: bursts per R1/R2/R3, order per R4, tlast per R5.
  task automatic add_desc(input int bias, input int s1, input int n1, input int s2, input int n2,
                          input int s3, input int n3, input int s4, input int n4);
    for (int d4 = 0; d4 < n4; d4++)
      for (int d3 = 0; d3 < n3; d3++)
        for (int d2 = 0; d2 < n2; d2++)
          for (int d1 = 0; d1 < n1; d1++) begin
            elem_t e;
            out_t  o;
            e.addr = bias + d4 * s4 + d3 * s3 + d2 * s2 + d1 * s1;
            e.unit = (s1 == 1);
            e.row  = (d1 == n1 - 1);
            e.desc = e.row && (d2 == n2 - 1) && (d3 == n3 - 1) && (d4 == n4 - 1);
            addr_q.push_back(e);
            o.data = memval(e.addr);
            o.last = e.desc;
            exp_out_q.push_back(o);
            if (open_cnt == 0) open_base = e.addr;
            open_cnt++;
            if (!e.unit || e.row || e.desc || open_cnt == MB) begin
              req_t r;
              r.addr = open_base;
              r.len  = open_cnt;
              exp_req_q.push_back(r);
              open_cnt = 0;
            end
          end
  endtask

  initial begin
    bit prev_wait;
    int prev_addr, prev_len, cyc;
    rst_n = 1'b0;
    ag_valid = 1'b0; ag_addr = '0; ag_unit = 1'b0; ag_row_end = 1'b0; ag_desc_end = 1'b0;
    mrq_ready = 1'b0; mrs_valid = 1'b0; mrs_data = '0; st_tready = 1'b0;
    prev_wait = 1'b0; prev_addr = 0; prev_len = 0;

    add_desc(0, 1, 8, 8, 3, 56, 2, 0, 1);    // long unit rows: R2 split at MB
    add_desc(3, 1, 3, 8, 2, 56, 1, 0, 1);    // short unit rows: R1
    add_desc(0, 8, 5, 1, 3, 56, 1, 0, 1);    // non-unit stride: R3
    add_desc(100, 1, 1, 2, 4, 0, 1, 0, 1);   // unit rows of one element
    add_desc(200, 1, 4, 16, 2, 64, 1, 500, 2); // rows exactly MB long, four dimensions

    repeat (3) @(negedge clk);
    check(st_tvalid == 1'b0, "R8 tvalid in reset", EW'(st_tvalid), '0);
    check(mrq_valid == 1'b0, "R8 mrq_valid in reset", EW'(mrq_valid), '0);
    check(ag_ready == 1'b1, "R8 ag_ready in reset", EW'(ag_ready), EW'(1));
    rst_n = 1'b1;

    cyc = 0;
    while ((addr_q.size() > 0 || exp_out_q.size() > 0) && cyc < 20000) begin
      @(negedge clk);
      if (prev_wait) begin
        check(mrq_valid == 1'b1, "R9 request withdrawn", EW'(mrq_valid), EW'(1));
        check(int'(mrq_addr) == prev_addr && int'(mrq_len) == prev_len,
              "R9 request changed while waiting", EW'(mrq_addr), EW'(prev_addr));
      end
      ag_valid = (addr_q.size() > 0) && ($urandom % 4 != 0);
      if (addr_q.size() > 0) begin
        ag_addr = AW'(addr_q[0].addr);
        ag_unit = addr_q[0].unit;
        ag_row_end = addr_q[0].row;
        ag_desc_end = addr_q[0].desc;
      end
      mrq_ready = ($urandom % 3 != 0);
      mrs_valid = (rsp_q.size() > 0) && ($urandom % 2 == 0);
      mrs_data = (rsp_q.size() > 0) ? memval(rsp_q[0]) : '0;
      st_tready = (cyc < 80) ? 1'b0 : ($urandom % 4 != 0);
      #4;
      if (cyc == 79) begin
        check(occ == MO, "R7 buffer not filled during stall", EW'(occ), EW'(MO));
        check(mrs_ready == 1'b0, "R7 response accepted while full", EW'(mrs_ready), '0);
        check(mrq_valid == 1'b0, "R6 request issued beyond credit", EW'(mrq_valid), '0);
      end
      if (ag_valid && ag_ready) void'(addr_q.pop_front());
      if (mrq_valid && mrq_ready) begin
        if (exp_req_q.size() == 0) begin
          check(1'b0, "R1 R2 R3 unexpected request", EW'(mrq_addr), '0);
        end else begin
          req_t r;
          r = exp_req_q.pop_front();
          check(int'(mrq_addr) == r.addr, "R1 R3 request address", EW'(mrq_addr), EW'(r.addr));
          check(int'(mrq_len) == r.len, "R1 R2 R3 request length", EW'(mrq_len), EW'(r.len));
        end
        for (int i = 0; i < int'(mrq_len); i++) rsp_q.push_back(int'(mrq_addr) + i);
        inflight += int'(mrq_len);
        check(inflight <= MO, "R6 outstanding beats", EW'(inflight), EW'(MO));
      end
      if (mrs_valid && mrs_ready) begin
        void'(rsp_q.pop_front());
        occ++;
      end
      if (st_tvalid && st_tready) begin
        if (exp_out_q.size() == 0) begin
          check(1'b0, "R4 unexpected element", st_tdata, '0);
        end else begin
          out_t o;
          o = exp_out_q.pop_front();
          check(st_tdata == o.data, "R4 element data/order", st_tdata, o.data);
          check(st_tlast == o.last, "R5 tlast", EW'(st_tlast), EW'(o.last));
        end
        inflight--;
        occ--;
      end
      if (occ > MO) check(1'b0, "R7 buffer overflow", EW'(occ), EW'(MO));
      prev_wait = mrq_valid && !mrq_ready;
      prev_addr = int'(mrq_addr);
      prev_len  = int'(mrq_len);
      cyc++;
    end

    if (cyc >= 20000) check(1'b0, "watchdog expired", EW'(cyc), '0);
    check(exp_req_q.size() == 0, "R1 R2 R3 requests missing", EW'(exp_req_q.size()), '0);
    check(exp_out_q.size() == 0, "R4 elements missing", EW'(exp_out_q.size()), '0);
    repeat (4) @(negedge clk);
    check(st_tvalid == 1'b0, "R4 extra element", EW'(st_tvalid), '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule